// File: doc/BRIEF.md
# DRAM Refresh and Power-Up Sequencer

This block keeps an asynchronous DRAM alive and brings it up after reset. Once reset is released it holds the memory idle for a programmable number of clocks. It then runs a programmable number of back-to-back refresh cycles, in which the column strobes go low before the row strobe, and only then raises `ready`. Because the memory advances its own internal row counter on this kind of cycle, the block never drives an address.

After start-up a free-running interval timer adds one unit of refresh debt every `REF_INTERVAL` clocks. The debt is held in a counter that saturates at `PEND_MAX`. While debt is outstanding the block raises `ref_req` to the access controller and holds it until `ref_gnt` arrives. The controller asserts the grant only after it has finished its current memory cycle. The sequencer then owns the row strobe, both column strobes and the write enable. It pays off all of the debt in one burst, keeping the column strobes low between chained cycles. It hands the pins back with a one-clock `ref_done` pulse.

Each refresh cycle has three phases, each a whole number of clocks. First comes a row precharge of `T_RP` clocks with the row strobe high. Next is a strobe lead of `T_CSR` clocks with the column strobes low. Last, the row strobe is low for `T_RAS` clocks. These parameters let the block meet the memory's minimum times at any clock rate.

Top module: `dram_refresh_seq`

## Requirements
- R1: While `rst` is high (synchronous, active high): `ready`, `ref_req` and `ref_done` are 0; `ras_n`, `lcas_n` and `ucas_n` are 1; `strobe_own` is 1.
- R2: After reset is released, `ras_n` stays high for at least `PAUSE_CYC` clocks. The first row-strobe fall comes no later than `PAUSE_CYC + T_RP + T_CSR + 2` clocks after release.
- R3: Exactly `INIT_CYC` refresh cycles run before `ready` rises. Once high, `ready` stays high until the next reset.
- R4: `lcas_n` and `ucas_n` always carry the same value. Whenever `ras_n` falls, both strobes are low and have been low for at least `T_CSR` clocks.
- R5: Every row-strobe low pulse lasts exactly `T_RAS` clocks. Every row-strobe high interval before a fall lasts at least `T_RP` clocks.
- R6: Within one initialization run or one grant, the column strobes stay low between chained cycles: in a run of n cycles, n-1 of them follow on without the strobes rising. The column strobes never rise while `ras_n` is low, and they are high once the run ends.
- R7: After `ready`, one unit of debt is added every `REF_INTERVAL` clocks, so with prompt grants successive `ref_req` rises are `REF_INTERVAL` clocks apart. Debt saturates at `PEND_MAX`, and ticks beyond that are lost.
- R8: `ref_req` rises when debt is nonzero and stays high until `ref_gnt` is seen. It is low once the sequencer is running under the grant.
- R9: Under a grant, the number of refresh cycles equals the outstanding debt. The run is followed by a single-clock `ref_done`, and `strobe_own` is low on the next clock.
- R10: `ras_n` is low only while `strobe_own` is 1. While not owning, the block drives all strobes high.
- R11: `we_n` is high whenever `strobe_own` is 1.
- R12: Asserting `rst` at any time drops `ready` and restarts the full pause and initialization.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| ref_gnt | input | 1 | Access controller hands over the memory pins |
| ref_req | output | 1 | Refresh debt outstanding, asking for the pins |
| ref_done | output | 1 | One-clock pulse: refresh burst finished, pins released |
| ready | output | 1 | Initialization complete; normal accesses allowed |
| strobe_own | output | 1 | Sequencer is currently driving the strobes and write enable |
| ras_n | output | 1 | Row strobe, active low |
| lcas_n | output | 1 | Lower column strobe, active low |
| ucas_n | output | 1 | Upper column strobe, active low |
| we_n | output | 1 | Write enable, active low (held high) |

## Verification
The assertions assume that the access controller keeps `ref_gnt` high from its first assertion until `ref_done`, and raises it only in answer to `ref_req`. The bench meets this by driving the grant only after it sees the request, and lowering it on the clock after the done pulse. The grant delays are multiples of the refresh interval plus a small offset, so each burst starts well clear of the next tick and finishes before it. As a result, the debt each grant must pay is known arithmetically: one more than the number of whole intervals waited, capped at the saturation depth.

// File: rtl/dram_ref_pkg.sv
package dram_ref_pkg;

  typedef enum logic [2:0] {
    SQ_PAUSE,
    SQ_INIT,
    SQ_IDLE,
    SQ_REQ,
    SQ_RUN,
    SQ_DONE
  } seq_state_t;

  typedef enum logic [1:0] {
    PH_IDLE,
    PH_PRE,
    PH_LEAD,
    PH_LOW
  } phase_t;

endpackage

// File: rtl/ref_cbr_engine.sv
module ref_cbr_engine
  import dram_ref_pkg::*;
#(
  parameter int T_RP  = 4,
  parameter int T_CSR = 1,
  parameter int T_RAS = 6
) (
  input  logic clk,
  input  logic rst,
  input  logic go,
  output logic busy,
  output logic cyc_end,
  output logic ras_n,
  output logic cas_n
);
  localparam int CW = $clog2(T_RP + T_CSR + T_RAS + 1);

  phase_t        ph;
  logic [CW-1:0] cnt;
  logic          chain;

  // One cycle: precharge, strobe lead, row low. Chained cycles keep the
  // column strobe low through the precharge.
  always_ff @(posedge clk) begin
    if (rst) begin
      ph    <= PH_IDLE;
      cnt   <= '0;
      chain <= 1'b0;
    end else begin
      case (ph)
        PH_IDLE: begin
          if (go) begin
            ph    <= PH_PRE;
            cnt   <= CW'(T_RP - 1);
            chain <= 1'b0;
          end
        end
        PH_PRE: begin
          if (cnt == '0) begin
            ph  <= PH_LEAD;
            cnt <= CW'(T_CSR - 1);
          end else begin
            cnt <= cnt - CW'(1);
          end
        end
        PH_LEAD: begin
          if (cnt == '0) begin
            ph  <= PH_LOW;
            cnt <= CW'(T_RAS - 1);
          end else begin
            cnt <= cnt - CW'(1);
          end
        end
        default: begin
          if (cnt == '0) begin
            if (go) begin
              ph    <= PH_PRE;
              cnt   <= CW'(T_RP - 1);
              chain <= 1'b1;
            end else begin
              ph    <= PH_IDLE;
              chain <= 1'b0;
            end
          end else begin
            cnt <= cnt - CW'(1);
          end
        end
      endcase
    end
  end

  assign busy    = (ph != PH_IDLE);
  assign cyc_end = (ph == PH_LOW) && (cnt == '0);
  assign ras_n   = (ph != PH_LOW);
  assign cas_n   = !((ph == PH_LEAD) || (ph == PH_LOW) || ((ph == PH_PRE) && chain));

endmodule

// File: rtl/ref_backlog.sv
module ref_backlog #(
  parameter int REF_INTERVAL = 1560,
  parameter int PEND_MAX     = 4
) (
  input  logic                             clk,
  input  logic                             rst,
  input  logic                             en,
  input  logic                             take,
  output logic                             tick,
  output logic [$clog2(PEND_MAX+1)-1:0]    pending
);
  localparam int TW = $clog2(REF_INTERVAL);
  localparam int PW = $clog2(PEND_MAX + 1);

  logic [TW-1:0] tcnt;

  assign tick = en && (tcnt == TW'(REF_INTERVAL - 1));

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      tcnt <= '0;
    end else if (tick) begin
      tcnt <= '0;
    end else begin
      tcnt <= tcnt + TW'(1);
    end
  end

  // Saturating debt: a tick and a completed cycle in the same clock cancel.
  always_ff @(posedge clk) begin
    if (rst) begin
      pending <= '0;
    end else begin
      case ({tick, take})
        2'b10:   if (pending != PW'(PEND_MAX)) pending <= pending + PW'(1);
        2'b01:   if (pending != '0) pending <= pending - PW'(1);
        default: pending <= pending;
      endcase
    end
  end

endmodule

// File: rtl/dram_refresh_seq.sv
module dram_refresh_seq
  import dram_ref_pkg::*;
#(
  parameter int PAUSE_CYC    = 20000,
  parameter int INIT_CYC     = 8,
  parameter int REF_INTERVAL = 1560,
  parameter int PEND_MAX     = 4,
  parameter int T_RP         = 4,
  parameter int T_CSR        = 1,
  parameter int T_RAS        = 6
) (
  input  logic clk,
  input  logic rst,
  input  logic ref_gnt,
  output logic ref_req,
  output logic ref_done,
  output logic ready,
  output logic strobe_own,
  output logic ras_n,
  output logic lcas_n,
  output logic ucas_n,
  output logic we_n
);
  localparam int PCW = $clog2(PAUSE_CYC + 1);
  localparam int ICW = $clog2(INIT_CYC + 1);
  localparam int DW  = $clog2(PEND_MAX + 1);

  seq_state_t     st;
  logic [PCW-1:0] pcnt;
  logic [ICW-1:0] ileft;
  logic [DW-1:0]  pending;
  logic           tick, go, busy, cyc_end, eng_ras_n, eng_cas_n, take;

  assign ready = (st != SQ_PAUSE) && (st != SQ_INIT);
  assign take  = cyc_end && (st == SQ_RUN);

  // Ask the engine for another cycle while work remains after this one.
  always_comb begin
    case (st)
      SQ_INIT: go = cyc_end ? (ileft > ICW'(1)) : (ileft != '0);
      SQ_RUN:  go = cyc_end ? ((pending > DW'(1)) || tick) : (pending != '0);
      default: go = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st    <= SQ_PAUSE;
      pcnt  <= '0;
      ileft <= '0;
    end else begin
      case (st)
        SQ_PAUSE: begin
          if (pcnt == PCW'(PAUSE_CYC - 1)) begin
            st    <= SQ_INIT;
            ileft <= ICW'(INIT_CYC);
          end else begin
            pcnt <= pcnt + PCW'(1);
          end
        end
        SQ_INIT: begin
          if (cyc_end) ileft <= ileft - ICW'(1);
          if (!busy && ileft == '0) st <= SQ_IDLE;
        end
        SQ_IDLE: if (pending != '0) st <= SQ_REQ;
        SQ_REQ:  if (ref_gnt) st <= SQ_RUN;
        SQ_RUN:  if (!busy && pending == '0) st <= SQ_DONE;
        default: st <= SQ_IDLE;
      endcase
    end
  end

  ref_backlog #(
    .REF_INTERVAL(REF_INTERVAL),
    .PEND_MAX    (PEND_MAX)
  ) u_backlog (
    .clk    (clk),
    .rst    (rst),
    .en     (ready),
    .take   (take),
    .tick   (tick),
    .pending(pending)
  );

  ref_cbr_engine #(
    .T_RP (T_RP),
    .T_CSR(T_CSR),
    .T_RAS(T_RAS)
  ) u_engine (
    .clk    (clk),
    .rst    (rst),
    .go     (go),
    .busy   (busy),
    .cyc_end(cyc_end),
    .ras_n  (eng_ras_n),
    .cas_n  (eng_cas_n)
  );

  assign ref_req    = (st == SQ_REQ);
  assign ref_done   = (st == SQ_DONE);
  assign strobe_own = (st == SQ_PAUSE) || (st == SQ_INIT) || (st == SQ_RUN) || (st == SQ_DONE);
  assign ras_n      = eng_ras_n;
  assign lcas_n     = eng_cas_n;
  assign ucas_n     = eng_cas_n;
  assign we_n       = 1'b1;

endmodule

// File: rtl/dram_refresh_seq_chk.sv
module dram_refresh_seq_chk #(
  parameter int T_RAS = 6
) (
  input logic clk,
  input logic rst,
  input logic ref_gnt,
  input logic ref_req,
  input logic ref_done,
  input logic ready,
  input logic strobe_own,
  input logic ras_n,
  input logic lcas_n,
  input logic ucas_n,
  input logic we_n
);
  int lo_cnt;

  always_ff @(posedge clk) begin
    if (rst) lo_cnt <= 0;
    else     lo_cnt <= ras_n ? 0 : lo_cnt + 1;
  end

  // R4
  ras_fall_lead_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(ras_n) |-> (!lcas_n && !ucas_n && $past(!lcas_n)));

  // R4
  strobe_pair_chk: assert property (@(posedge clk) disable iff (rst)
    lcas_n == ucas_n);

  // R5
  ras_width_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(ras_n) |-> (lo_cnt == T_RAS));

  // R6
  cas_rise_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(lcas_n) |-> ras_n);

  // R10
  ras_owned_chk: assert property (@(posedge clk) disable iff (rst)
    !ras_n |-> strobe_own);

  // R11
  we_hold_chk: assert property (@(posedge clk) disable iff (rst)
    strobe_own |-> we_n);

  // R9
  done_release_chk: assert property (@(posedge clk) disable iff (rst)
    ref_done |=> (!ref_done && !strobe_own));

  // R8
  req_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (ref_req && !ref_gnt) |=> ref_req);

  // R3
  ready_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    ready |=> ready);

endmodule

bind dram_refresh_seq dram_refresh_seq_chk #(.T_RAS(T_RAS)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .ref_gnt   (ref_gnt),
  .ref_req   (ref_req),
  .ref_done  (ref_done),
  .ready     (ready),
  .strobe_own(strobe_own),
  .ras_n     (ras_n),
  .lcas_n    (lcas_n),
  .ucas_n    (ucas_n),
  .we_n      (we_n)
);

// File: tb/dram_refresh_seq_test.sv
module dram_refresh_seq_test;
  localparam int CLK_PERIOD = 10;
  localparam int PAUSE = 20;
  localparam int INIT  = 8;
  localparam int TRP   = 3;
  localparam int TCSR  = 2;
  localparam int TRAS  = 4;
  localparam int INTV  = 64;
  localparam int PMAX  = 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ref_gnt = 1'b0;
  logic ref_req, ref_done, ready, strobe_own, ras_n, lcas_n, ucas_n, we_n;

  dram_refresh_seq #(
    .PAUSE_CYC(PAUSE), .INIT_CYC(INIT), .REF_INTERVAL(INTV), .PEND_MAX(PMAX),
    .T_RP(TRP), .T_CSR(TCSR), .T_RAS(TRAS)
  ) uut (
    .clk(clk), .rst(rst), .ref_gnt(ref_gnt), .ref_req(ref_req), .ref_done(ref_done),
    .ready(ready), .strobe_own(strobe_own), .ras_n(ras_n), .lcas_n(lcas_n),
    .ucas_n(ucas_n), .we_n(we_n)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int n_checks = 0;
  int n_err = 0;
  int cyc = 0;
  bit finished = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // Pin monitor: strobe ordering and widths, sampled mid-cycle.
  bit prev_ras = 1'b1;
  int ras_lo_len = 0;
  int ras_hi_len = 0;
  int cas_lo_len = 0;
  int ras_falls = 0;
  int chained = 0;

  always @(negedge clk) begin
    if (rst) begin
      prev_ras   = 1'b1;
      ras_lo_len = 0;
      ras_hi_len = 0;
      cas_lo_len = 0;
    end else begin
      if (prev_ras && !ras_n) begin
        ras_falls++;
        chk(!lcas_n && !ucas_n && cas_lo_len >= TCSR, "R4 strobe lead", cas_lo_len, TCSR);
        chk(ras_hi_len >= TRP, "R5 precharge", ras_hi_len, TRP);
        chk(strobe_own && we_n, "R10/R11 owned with write high", {strobe_own, we_n}, 3);
        if (cas_lo_len >= ras_hi_len) chained++;
      end
      if (!prev_ras && ras_n)
        chk(ras_lo_len == TRAS, "R5 row low width", ras_lo_len, TRAS);
      ras_lo_len = ras_n ? 0 : ras_lo_len + 1;
      ras_hi_len = ras_n ? ras_hi_len + 1 : 0;
      cas_lo_len = lcas_n ? 0 : cas_lo_len + 1;
      prev_ras   = ras_n;
    end
  end

  task automatic startup(input string tag);
    int n = 0;
    bit early_ready = 1'b0;
    while (ras_n) begin
      @(negedge clk);
      n++;
      if (ready) early_ready = 1'b1;
    end
    chk(n >= PAUSE && n <= PAUSE + TRP + TCSR + 2, tag, n, PAUSE);
    chk(!early_ready, {tag, " ready during pause"}, int'(early_ready), 0);
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
    $finish;
  endtask

  initial begin
    int f0, c0, exp_n;
    int rise[6];
    bit held;
    repeat (3) @(negedge clk);
    // R1
    chk(!ready && !ref_req && ras_n && lcas_n && ucas_n && strobe_own && !ref_done,
        "R1 reset state", {ready, ref_req, ras_n, lcas_n, ucas_n, strobe_own, ref_done}, 30);
    f0 = ras_falls;
    c0 = chained;
    rst = 1'b0;
    startup("R2 pause length");
    while (!ready) @(negedge clk);
    chk(ras_falls - f0 == INIT, "R3 init cycle count", ras_falls - f0, INIT);
    chk(chained - c0 == INIT - 1, "R6 chained init cycles", chained - c0, INIT - 1);

    for (int k = 0; k < 5; k++) begin
      while (!ref_req) @(negedge clk);
      rise[k] = cyc;
      chk(!strobe_own && ras_n && lcas_n && ucas_n, "R10 released pins idle",
          {strobe_own, ras_n, lcas_n, ucas_n}, 7);
      f0 = ras_falls;
      c0 = chained;
      held = 1'b1;
      repeat (k * INTV + 5) begin
        @(negedge clk);
        if (!ref_req) held = 1'b0;
      end
      chk(held, "R8 request held until grant", int'(held), 1);
      ref_gnt = 1'b1;
      @(negedge clk);
      chk(!ref_req && strobe_own, "R8 request drops under grant", {ref_req, strobe_own}, 1);
      while (!ref_done) @(negedge clk);
      exp_n = (k + 1 < PMAX) ? k + 1 : PMAX;
      chk(ras_falls - f0 == exp_n, "R9/R7 burst length and saturation", ras_falls - f0, exp_n);
      chk(chained - c0 == exp_n - 1, "R6 chained burst cycles", chained - c0, exp_n - 1);
      ref_gnt = 1'b0;
      @(negedge clk);
      chk(!ref_done && !strobe_own, "R9 single done then release", {ref_done, strobe_own}, 0);
      chk(ras_n && lcas_n && ucas_n, "R6 strobes high after run", {ras_n, lcas_n, ucas_n}, 7);
    end
    while (!ref_req) @(negedge clk);
    rise[5] = cyc;
    for (int k = 0; k < 5; k++)
      chk(rise[k+1] - rise[k] == (k + 1) * INTV, "R7 tick period",
          rise[k+1] - rise[k], (k + 1) * INTV);

    // R12
    rst = 1'b1;
    repeat (2) @(negedge clk);
    chk(!ready && !ref_req, "R12 reset drops ready", {ready, ref_req}, 0);
    rst = 1'b0;
    startup("R12 pause restarts");
    finished = 1'b1;
    summary();
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!finished) begin
      n_checks++;
      n_err++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      summary();
    end
  end

endmodule